// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number after a translation cache miss. It takes one lookup request at a time. It forms the address of the matching table entry by adding the page number to a table base register. It then fetches that entry with a single-beat memory read and answers with either the physical page number or a page-fault indication.

Along the way, the walker keeps the entry's bookkeeping bits current. The first touch of a page sets its referenced bit. A store to a page whose modified bit is clear sets that bit. Each of these updates costs one extra write to the same entry, and it is issued only when a bit actually changes. Invalid entries are reported as faults and are never written.

Top module: `page_walker`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid`, `memRdEn` and `memWrEn` are 0, and the table base register holds 0.
- R2: A cycle with `baseLoad` high stores `baseValue` into the table base. A request accepted while `reqValid` and `reqReady` are both high produces `memRdEn` for exactly one cycle, in the next cycle. The read address is `(base + vpn) mod 2^MEM_AW`.
- R3: `reqReady` stays low from the cycle after acceptance through the response cycle. It returns high in the cycle after `rspValid`.
- R4: The walker waits any number of cycles for `memRdValid`. `memRdData` is taken only in a cycle where `memRdValid` is high.
- R5: An entry is 14 bits wide: bit 13 is valid, bit 12 is dirty, bit 11 is referenced, bits 10:6 are reserved, and bits 5:0 are the PPN. For a valid entry, the response carries `rspFault`=0 and `rspPpn` equal to the entry's PPN.
- R6: For an entry whose valid bit is 0, the response carries `rspFault`=1 and `rspPpn`=0, and no memory write occurs.
- R7: If a valid entry has its referenced bit clear, the walker issues one `memWrEn` cycle in the cycle after the data beat. The write goes to the read address and carries the entry with the referenced bit set. All other bits are kept, including the reserved bits.
- R8: A store (`reqStore`=1) to a valid entry whose dirty bit is clear writes the entry back with both the dirty bit and the referenced bit set.
- R9: If no bit needs to change, there is no write. `rspValid` is high for exactly one cycle: in the cycle after the data beat when there is no write, or in the cycle after the write when there is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseLoad | input | 1 | Load strobe for the table base register |
| baseValue | input | MEM_AW | New table base value |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVpn | input | VPN_W | Virtual page number to resolve |
| reqStore | input | 1 | The access behind the miss is a store |
| memRdEn | output | 1 | Single-beat read strobe |
| memWrEn | output | 1 | Entry write-back strobe |
| memAddr | output | MEM_AW | Entry address for the read and the write |
| memWrData | output | PTE_W | Updated entry word |
| memRdValid | input | 1 | Read data beat present |
| memRdData | input | PTE_W | Entry word returned by memory |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Page fault: the entry is not valid |
| rspPpn | output | PPN_W | Physical page number, zero on a fault |

## Verification
The vector table runs walks in a fixed sequence against a modelled table of entries. This separates the three outcomes of a walk: a first touch that sets the referenced bit, a repeat touch that writes nothing, and a store that promotes a clean entry to dirty. Invalid entries are included whose stale PPN fields are nonzero, which shows that the PPN is forced to zero on a fault. One entry has reserved bits set, so a write-back that drops those bits is caught. Directed cases move the base so the address wraps, and slow the memory so that waiting for the data beat is observable in the response latency.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_READ,
    WALK_WAIT,
    WALK_UPDATE,
    WALK_ANSWER
  } walkStateT;

  typedef struct packed {
    logic captureReq;
    logic issueRead;
    logic captureEntry;
    logic issueWrite;
    logic respond;
  } walkStrobeT;

endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRdValid,
  input  logic       rdEntryValid,
  input  logic       rdNeedUpdate,
  output logic       reqReady,
  output walkStrobeT strobe
);

  walkStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      WALK_IDLE: begin
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          stateD = WALK_READ;
        end
      end
      WALK_READ: begin
        strobe.issueRead = 1'b1;
        stateD = WALK_WAIT;
      end
      WALK_WAIT: begin
        if (memRdValid) begin
          strobe.captureEntry = 1'b1;
          stateD = (rdEntryValid && rdNeedUpdate) ? WALK_UPDATE : WALK_ANSWER;
        end
      end
      WALK_UPDATE: begin
        strobe.issueWrite = 1'b1;
        stateD = WALK_ANSWER;
      end
      WALK_ANSWER: begin
        strobe.respond = 1'b1;
        stateD = WALK_IDLE;
      end
      default: stateD = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= WALK_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == WALK_IDLE);

endmodule

// File: rtl/page_walker_datapath.sv
module page_walker_datapath
  import page_walker_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 6,
  parameter int PTE_W  = 14,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseLoad,
  input  logic [MEM_AW-1:0] baseValue,
  input  logic [VPN_W-1:0]  reqVpn,
  input  logic              reqStore,
  input  logic [PTE_W-1:0]  memRdData,
  input  walkStrobeT        strobe,
  output logic              rdEntryValid,
  output logic              rdNeedUpdate,
  output logic [MEM_AW-1:0] memAddr,
  output logic [PTE_W-1:0]  memWrData,
  output logic              rspFault,
  output logic [PPN_W-1:0]  rspPpn
);

  localparam int VALID_POS = PTE_W - 1;
  localparam int DIRTY_POS = PTE_W - 2;
  localparam int REF_POS   = PTE_W - 3;

  logic [MEM_AW-1:0] baseQ;
  logic [MEM_AW-1:0] addrQ;
  logic              storeQ;
  logic [PTE_W-1:0]  entryQ;
  logic              faultQ;

  always_ff @(posedge clk) begin
    if (!rstN) baseQ <= '0;
    else if (baseLoad) baseQ <= baseValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      storeQ <= 1'b0;
      entryQ <= '0;
      faultQ <= 1'b0;
    end else begin
      if (strobe.captureReq) begin
        addrQ  <= baseQ + MEM_AW'(reqVpn);
        storeQ <= reqStore;
      end
      if (strobe.captureEntry) begin
        entryQ <= memRdData;
        faultQ <= !memRdData[VALID_POS];
      end
    end
  end

  assign rdEntryValid = memRdData[VALID_POS];
  assign rdNeedUpdate = !memRdData[REF_POS] || (storeQ && !memRdData[DIRTY_POS]);

  always_comb begin
    memWrData = entryQ;
    memWrData[REF_POS] = 1'b1;
    if (storeQ) memWrData[DIRTY_POS] = 1'b1;
  end

  assign memAddr  = addrQ;
  assign rspFault = strobe.respond && faultQ;
  assign rspPpn   = (strobe.respond && !faultQ) ? entryQ[PPN_W-1:0] : '0;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 6,
  parameter int PTE_W  = 14,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseLoad,
  input  logic [MEM_AW-1:0] baseValue,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VPN_W-1:0]  reqVpn,
  input  logic              reqStore,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [PTE_W-1:0]  memWrData,
  input  logic              memRdValid,
  input  logic [PTE_W-1:0]  memRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [PPN_W-1:0]  rspPpn
);

  walkStrobeT strobe;
  logic       rdEntryValid;
  logic       rdNeedUpdate;

  page_walker_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRdValid   (memRdValid),
    .rdEntryValid (rdEntryValid),
    .rdNeedUpdate (rdNeedUpdate),
    .reqReady     (reqReady),
    .strobe       (strobe)
  );

  page_walker_datapath #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .PTE_W  (PTE_W),
    .MEM_AW (MEM_AW)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .baseLoad     (baseLoad),
    .baseValue    (baseValue),
    .reqVpn       (reqVpn),
    .reqStore     (reqStore),
    .memRdData    (memRdData),
    .strobe       (strobe),
    .rdEntryValid (rdEntryValid),
    .rdNeedUpdate (rdNeedUpdate),
    .memAddr      (memAddr),
    .memWrData    (memWrData),
    .rspFault     (rspFault),
    .rspPpn       (rspPpn)
  );

  assign memRdEn  = strobe.issueRead;
  assign memWrEn  = strobe.issueWrite;
  assign rspValid = strobe.respond;

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int PPN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic             wrValidBit,
  input logic             wrRefBit,
  input logic             rspValid,
  input logic             rspFault,
  input logic [PPN_W-1:0] rspPpn
);

  // R2
  accept_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memRdEn);

  // R2
  single_beat_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn || rspValid) |-> !reqReady);

  // R3
  ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R6
  fault_ppn_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPpn == '0);

  // R6
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> !$past(memWrEn));

  // R7
  write_sets_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> wrValidBit && wrRefBit);

  // R9
  write_then_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> rspValid);

  // R9
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

endmodule

bind page_walker page_walker_chk #(.PPN_W(PPN_W)) i_page_walker_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .wrValidBit (memWrData[PTE_W-1]),
  .wrRefBit   (memWrData[PTE_W-3]),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspPpn     (rspPpn)
);

// File: tb/test_page_walker.sv
module test_page_walker;

  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 8;
  localparam int PPN_W = 6;
  localparam int PTE_W = 14;
  localparam int MEM_AW = 10;
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam logic [MEM_AW-1:0] TABLE_BASE = 10'h100;

  // Vector: vpn, store, fault, ppn, writeback, entry after the walk
  localparam int VEC_W = 8 + 1 + 1 + 6 + 1 + 14;
  localparam int NUM_VEC = 11;
  localparam logic [VEC_W-1:0] VECS [NUM_VEC] = '{
    {8'h00, 1'b0, 1'b0, 6'h28, 1'b1, 14'h2828},
    {8'h00, 1'b0, 1'b0, 6'h28, 1'b0, 14'h2828},
    {8'h00, 1'b1, 1'b0, 6'h28, 1'b1, 14'h3828},
    {8'h00, 1'b1, 1'b0, 6'h28, 1'b0, 14'h3828},
    {8'h01, 1'b0, 1'b1, 6'h00, 1'b0, 14'h001F},
    {8'h04, 1'b1, 1'b1, 6'h00, 1'b0, 14'h0005},
    {8'h0F, 1'b1, 1'b0, 6'h0D, 1'b1, 14'h3D4D},
    {8'h0F, 1'b0, 1'b0, 6'h0D, 1'b0, 14'h3D4D},
    {8'h03, 1'b1, 1'b0, 6'h02, 1'b1, 14'h3802},
    {8'h0A, 1'b0, 1'b0, 6'h09, 1'b1, 14'h2809},
    {8'hFF, 1'b0, 1'b0, 6'h2A, 1'b1, 14'h282A}
  };

  localparam logic [PTE_W-1:0] LOW_ENTRIES [16] = '{
    14'h2028, 14'h001F, 14'h2033, 14'h2002, 14'h0005, 14'h2016, 14'h0000, 14'h0000,
    14'h2013, 14'h2017, 14'h2009, 14'h0000, 14'h0000, 14'h202D, 14'h2011, 14'h254D
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              baseLoad = 1'b0;
  logic [MEM_AW-1:0] baseValue = '0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [VPN_W-1:0]  reqVpn = '0;
  logic              reqStore = 1'b0;
  logic              memRdEn;
  logic              memWrEn;
  logic [MEM_AW-1:0] memAddr;
  logic [PTE_W-1:0]  memWrData;
  logic              memRdValid = 1'b0;
  logic [PTE_W-1:0]  memRdData = '0;
  logic              rspValid;
  logic              rspFault;
  logic [PPN_W-1:0]  rspPpn;

  logic [PTE_W-1:0]  mem [MEM_DEPTH];
  int                memLat = 1;
  logic              pend = 1'b0;
  int                waitCnt = 0;
  logic [MEM_AW-1:0] pendAddr = '0;
  logic [MEM_AW-1:0] lastRdAddr = '0;
  logic [MEM_AW-1:0] lastWrAddr = '0;
  int                wrCount = 0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_walker #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PTE_W(PTE_W), .MEM_AW(MEM_AW)
  ) i_page_walker (
    .clk(clk), .rstN(rstN), .baseLoad(baseLoad), .baseValue(baseValue),
    .reqValid(reqValid), .reqReady(reqReady), .reqVpn(reqVpn), .reqStore(reqStore),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .rspValid(rspValid), .rspFault(rspFault), .rspPpn(rspPpn)
  );

  // Memory model: the read data beat arrives memLat cycles after the strobe
  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (pend) begin
      if (waitCnt == 0) begin
        memRdValid <= 1'b1;
        memRdData  <= mem[pendAddr];
        pend       <= 1'b0;
      end else begin
        waitCnt <= waitCnt - 1;
      end
    end
    if (memRdEn) begin
      lastRdAddr <= memAddr;
      if (memLat <= 1) begin
        memRdValid <= 1'b1;
        memRdData  <= mem[memAddr];
      end else begin
        pend     <= 1'b1;
        waitCnt  <= memLat - 2;
        pendAddr <= memAddr;
      end
    end
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      lastWrAddr   <= memAddr;
      wrCount      <= wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadBase(input logic [MEM_AW-1:0] value);
    @(negedge clk);
    baseLoad  = 1'b1;
    baseValue = value;
    @(negedge clk);
    baseLoad  = 1'b0;
  endtask

  task automatic walk(input logic [VPN_W-1:0] vpn, input bit st,
                      output bit fault, output logic [PPN_W-1:0] ppn,
                      output int cyc, output int writes, output bit busyLow);
    int wrStart;
    @(negedge clk);
    wrStart  = wrCount;
    reqValid = 1'b1;
    reqVpn   = vpn;
    reqStore = st;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc      = 1;
    busyLow  = !reqReady;
    while (!rspValid && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (reqReady) busyLow = 1'b0;
    end
    fault  = rspFault;
    ppn    = rspPpn;
    writes = wrCount - wrStart;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit fault;
    logic [PPN_W-1:0] ppn;
    int cyc;
    int writes;
    bit busyLow;

    for (int a = 0; a < MEM_DEPTH; a++) mem[a] = '0;
    for (int v = 0; v < 256; v++) begin
      if (v < 16) mem[TABLE_BASE + v] = LOW_ENTRIES[v];
      else        mem[TABLE_BASE + v] = 14'h2000 | 14'((v & 6'h3F) ^ 6'h15);
    end
    mem[10'h008] = 14'h2007;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(rspValid == 1'b0, "R1", "rspValid", rspValid, 0);
    check(memRdEn == 1'b0 && memWrEn == 1'b0, "R1", "mem strobes", {memRdEn, memWrEn}, 0);

    // R1: base is zero after reset, so vpn 0x10 reads address 0x010
    walk(8'h10, 1'b0, fault, ppn, cyc, writes, busyLow);
    check(lastRdAddr == 10'h010, "R1", "address with reset base", lastRdAddr, 10'h010);

    // R2: load base, then run the vector table
    loadBase(TABLE_BASE);
    for (int i = 0; i < NUM_VEC; i++) begin
      logic [VPN_W-1:0] vVpn;
      logic vSt, vFault, vWb;
      logic [PPN_W-1:0] vPpn;
      logic [PTE_W-1:0] vAfter;
      logic [MEM_AW-1:0] vAddr;
      {vVpn, vSt, vFault, vPpn, vWb, vAfter} = VECS[i];
      vAddr = TABLE_BASE + MEM_AW'(vVpn);
      walk(vVpn, vSt, fault, ppn, cyc, writes, busyLow);
      check(lastRdAddr == vAddr, "R2", "read address", lastRdAddr, vAddr);
      check(busyLow, "R3", "reqReady low while busy", busyLow, 1);
      check(reqReady == 1'b1, "R3", "ready after response", reqReady, 1);
      check(fault == vFault, vFault ? "R6" : "R5", "fault", fault, vFault);
      check(ppn == vPpn, vFault ? "R6" : "R5", "ppn", ppn, vPpn);
      check(writes == int'(vWb), vSt ? "R8" : "R7", "write count", writes, vWb);
      check(mem[vAddr] == vAfter, vSt ? "R8" : "R7", "entry after walk", mem[vAddr], vAfter);
      check(cyc == 3 + int'(vWb), "R9", "response cycle", cyc, 3 + vWb);
      if (vWb) check(lastWrAddr == vAddr, "R7", "write address", lastWrAddr, vAddr);
    end

    // R4: slow memory, latency 3
    memLat = 3;
    walk(8'h0D, 1'b0, fault, ppn, cyc, writes, busyLow);
    check(ppn == 6'h2D && !fault, "R4", "ppn under slow memory", ppn, 6'h2D);
    check(cyc == 6, "R4", "response cycle under slow memory", cyc, 6);
    check(mem[TABLE_BASE + 10'h0D] == 14'h282D, "R4", "entry after slow walk",
          mem[TABLE_BASE + 10'h0D], 14'h282D);
    memLat = 1;

    // R2: base near top wraps the entry address
    loadBase(10'h3F8);
    walk(8'h10, 1'b0, fault, ppn, cyc, writes, busyLow);
    check(lastRdAddr == 10'h008, "R2", "wrapped address", lastRdAddr, 10'h008);
    check(ppn == 6'h07, "R2", "ppn at wrapped address", ppn, 6'h07);
    check(mem[10'h008] == 14'h2807, "R7", "wrapped entry ref set", mem[10'h008], 14'h2807);

    // R9: response is a single cycle
    check(rspValid == 1'b0, "R9", "rspValid dropped", rspValid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule